// File: doc/BRIEF.md
# Dynamic Bus Sizing Bridge

This block connects a 32-bit synchronous processor bus to targets with 32-, 16- or 8-bit data ports. The processor side presents a one-cycle transfer-start pulse with an address, a size code, a direction and write data. The bridge answers with a one-cycle acknowledge or error pulse. The processor bus has no address strobe of its own, so the bridge produces a level strobe for the target side. It holds the strobe until the selected target terminates the cycle with an acknowledge or a bus error.

Each target reports its port width with every acknowledge. The bridge learns the width on the first sub-cycle. If the port is narrower than the operand, it runs further sub-cycles and steps the address by the number of bytes moved each time. Read bytes are gathered into a holding register that is presented right-justified at the end. For writes, the first sub-cycle replicates the operand bytes so that every port width finds its bytes on the lanes it uses. Later sub-cycles drive only what the known port needs. Every transfer through the bridge is treated as uncached: data is never held past the transfer that fetched it.

Top module: `bus_width_bridge`

## Requirements
- R1: After reset, `t_as`, `m_ack`, `m_err` and `m_busy` are low and `t_ds` is zero.
- R2: `m_size` selects the operand: 00 = 4 bytes, 10 = 2 bytes, 01 = 1 byte, 11 = reserved. A reserved size, a 4-byte operand whose address is not a multiple of 4, or a 2-byte operand at an odd address is refused. `m_err` goes high for one cycle, in the cycle after the start, and no strobe is issued.
- R3: `t_as` rises in the cycle after an accepted start. It stays high with `t_addr` and `t_ds` stable until `t_ack` or `t_berr` is sampled high. It is then low for at least one cycle before the next sub-cycle.
- R4: `t_psize` returned with `t_ack` gives the port width: 00 = 32-bit, 10 = 16-bit, 01 = 8-bit. An operand of n bytes to a port of w bytes takes n/w sub-cycles when n > w, and one sub-cycle otherwise. The address advances by the bytes moved in each sub-cycle.
- R5: Byte lane 0 is bits 31:24 of `t_wdata`/`t_rdata`, and lane 3 is bits 7:0. A w-byte port uses lanes 0..w-1. Port lane k is enabled by `t_ds[o+k]`, where o is `t_addr` mod 4 rounded down to a multiple of w. `t_ds` marks the bytes still to be moved, from `t_addr` mod 4 upward. A write stores exactly the operand bytes, in big-endian order from the start address, and no neighbouring byte.
- R6: On a read, `m_rdata` holds the operand right-justified (the byte at the lowest address is the most significant) in the cycle `m_ack` is high. Unused upper bits are zero.
- R7: `m_ack` pulses once, one cycle after the last sub-cycle is acknowledged. With w wait cycles per sub-cycle and k sub-cycles, it goes high k*(2+w)-1 clock edges after the edge that accepts the start.
- R8: `t_berr` on any sub-cycle, or a port-size code of 11, ends the transfer. `m_err` pulses in the next cycle, `m_ack` stays low and no further strobe follows.
- R9: `m_ack` and `m_err` are never high together. `m_busy` is high from the cycle after an accepted start until the cycle the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_start | input | 1 | Transfer-start pulse, taken when idle |
| m_rnw | input | 1 | 1 = read, 0 = write |
| m_addr | input | AW | Byte address of the operand |
| m_size | input | 2 | Operand size code |
| m_wdata | input | 32 | Write operand, right-justified |
| m_ack | output | 1 | Transfer completed |
| m_err | output | 1 | Transfer refused or ended by error |
| m_rdata | output | 32 | Read operand, right-justified |
| m_busy | output | 1 | Transfer in progress |
| t_as | output | 1 | Target address strobe |
| t_rnw | output | 1 | Target direction |
| t_addr | output | AW | Target sub-cycle address |
| t_ds | output | 4 | Byte-lane data strobes |
| t_wdata | output | 32 | Target write lanes |
| t_ack | input | 1 | Target cycle acknowledge |
| t_berr | input | 1 | Target bus error |
| t_psize | input | 2 | Port-size code returned with the acknowledge |
| t_rdata | input | 32 | Target read lanes |

## Verification
A wrong byte index or port-width latch shows up in two places. A read returns the wrong value in the cycle `m_ack` rises. A write leaves a wrong byte in target memory, which a full memory compare after the transfer catches. A wrong remaining-count or step shows up as the wrong number of strobe rises. It also moves `m_ack` off its predicted edge or lets it fire early, so the error is visible within one transfer. A stuck sequencer state shows either as a strobe that never falls or as a missing response pulse, within one sub-cycle of the fault.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_t;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [1:0] PS_32 = 2'b00;
  localparam logic [1:0] PS_8  = 2'b01;
  localparam logic [1:0] PS_16 = 2'b10;

  // operand length in bytes, 0 for the reserved code
  function automatic logic [2:0] op_bytes(input logic [1:0] sz);
    case (sz)
      SZ_LONG: return 3'd4;
      SZ_WORD: return 3'd2;
      SZ_BYTE: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // port width in bytes, 0 for the reserved code
  function automatic logic [2:0] port_bytes(input logic [1:0] ps);
    case (ps)
      PS_32:   return 3'd4;
      PS_16:   return 3'd2;
      PS_8:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic is_aligned(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_LONG: return off == 2'b00;
      SZ_WORD: return off[0] == 1'b0;
      SZ_BYTE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // bytes a port of pb bytes can move starting at offset off
  function automatic logic [2:0] step_len(input logic [2:0] pb, input logic [1:0] off,
                                          input logic [2:0] rem);
    logic [2:0] po;
    logic [2:0] avail;
    po    = {1'b0, off} & (pb - 3'd1);
    avail = pb - po;
    return (rem < avail) ? rem : avail;
  endfunction

  // lanes covered by rem bytes starting at offset off (32-bit view)
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [2:0] rem);
    logic [3:0] m;
    for (int l = 0; l < LANES; l++)
      m[l] = (4'(l) >= {2'b00, off}) && (4'(l) < ({2'b00, off} + {1'b0, rem}));
    return m;
  endfunction

  function automatic logic [4:0] byte_shift(input logic [2:0] n, input logic [2:0] i);
    logic [2:0] k;
    k = n - 3'd1 - i;
    return {k[1:0], 3'b000};
  endfunction

  // byte i (0 = most significant) of an n-byte right-justified operand
  function automatic logic [7:0] pick_byte(input logic [31:0] d, input logic [2:0] n,
                                           input logic [2:0] i);
    logic [31:0] t;
    t = d >> byte_shift(n, i);
    return t[7:0];
  endfunction

  function automatic logic [31:0] place_byte(input logic [31:0] h, input logic [2:0] n,
                                             input logic [2:0] i, input logic [7:0] b);
    logic [31:0] mask;
    mask = 32'h0000_00FF << byte_shift(n, i);
    return (h & ~mask) | ({24'd0, b} << byte_shift(n, i));
  endfunction
endpackage

// File: rtl/bwb_wr_steer.sv
module bwb_wr_steer
  import bwb_pkg::*;
(
  input  logic              active,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        n_total,
  input  logic [2:0]        idx,
  input  logic [2:0]        rep,
  input  logic [1:0]        off,
  input  logic [2:0]        rem,
  output logic [DATA_W-1:0] lanes_data,
  output logic [LANES-1:0]  lanes_en
);
  // rep is the span the byte pattern repeats over: the whole operand while the
  // port width is unknown, the port width afterwards
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2:0] src;
    assign src = idx + (3'(l) & (rep - 3'd1));
    assign lanes_data[DATA_W-1-BYTE_W*l -: BYTE_W] = wr ? pick_byte(wdata, n_total, src) : 8'h00;
  end

  assign lanes_en = active ? lane_mask(off, rem) : '0;
endmodule

// File: rtl/bwb_rd_pack.sv
module bwb_rd_pack
  import bwb_pkg::*;
(
  input  logic [DATA_W-1:0] hold,
  input  logic [DATA_W-1:0] rdata,
  input  logic [2:0]        n_total,
  input  logic [2:0]        idx,
  input  logic [2:0]        pb,
  input  logic [1:0]        off,
  input  logic [2:0]        cnt,
  output logic [DATA_W-1:0] packed_q
);
  logic [2:0] port_off;
  assign port_off = {1'b0, off} & (pb - 3'd1);

  always_comb begin
    packed_q = hold;
    for (int j = 0; j < LANES; j++) begin
      logic [2:0]  lane;
      logic [31:0] t;
      lane = port_off + 3'(j);
      t    = rdata << {lane[1:0], 3'b000};
      if (3'(j) < cnt)
        packed_q = place_byte(packed_q, n_total, idx + 3'(j), t[31:24]);
    end
  end
endmodule

// File: rtl/bwb_seq.sv
module bwb_seq
  import bwb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       req_ok,
  input  logic       sub_hit,
  input  logic       sub_bad,
  input  logic       sub_last,
  output seq_state_t state,
  output logic       ack_q,
  output logic       err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      case (state)
        SQ_IDLE: if (accept) begin
          if (req_ok) state <= SQ_RUN;
          else        err_q <= 1'b1;
        end
        SQ_RUN: if (sub_hit) begin
          if (sub_bad) begin
            state <= SQ_IDLE;
            err_q <= 1'b1;
          end else if (sub_last) begin
            state <= SQ_IDLE;
            ack_q <= 1'b1;
          end else begin
            state <= SQ_GAP;
          end
        end
        SQ_GAP:  state <= SQ_RUN;
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_width_bridge.sv
module bus_width_bridge
  import bwb_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_start,
  input  logic          m_rnw,
  input  logic [AW-1:0] m_addr,
  input  logic [1:0]    m_size,
  input  logic [31:0]   m_wdata,
  output logic          m_ack,
  output logic          m_err,
  output logic [31:0]   m_rdata,
  output logic          m_busy,
  output logic          t_as,
  output logic          t_rnw,
  output logic [AW-1:0] t_addr,
  output logic [3:0]    t_ds,
  output logic [31:0]   t_wdata,
  input  logic          t_ack,
  input  logic          t_berr,
  input  logic [1:0]    t_psize,
  input  logic [31:0]   t_rdata
);
  seq_state_t  state;
  logic        rnw_q;
  logic [2:0]  n_q;
  logic [31:0] wdata_q;
  logic [AW-1:0] addr_q;
  logic [2:0]  idx_q;
  logic [2:0]  rem_q;
  logic [2:0]  pb_q;       // 0 until the first acknowledge reports a width
  logic [31:0] hold_q;
  logic [31:0] hold_next;

  // named events, also watched by the checker
  logic       accept;
  logic       req_ok;
  logic       sub_hit;
  logic       sub_bad;
  logic       sub_last;
  logic [2:0] pb_now;
  logic [2:0] cnt;
  logic [2:0] rep;

  assign accept   = (state == SQ_IDLE) && m_start;
  assign req_ok   = is_aligned(m_size, m_addr[1:0]) && (op_bytes(m_size) != 3'd0);
  assign sub_hit  = (state == SQ_RUN) && (t_ack || t_berr);
  assign pb_now   = port_bytes(t_psize);
  assign sub_bad  = t_berr || (pb_now == 3'd0);
  assign cnt      = step_len(pb_now, addr_q[1:0], rem_q);
  assign sub_last = (rem_q == cnt);
  assign rep      = (pb_q == 3'd0) ? n_q : pb_q;

  bwb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_ok   (req_ok),
    .sub_hit  (sub_hit),
    .sub_bad  (sub_bad),
    .sub_last (sub_last),
    .state    (state),
    .ack_q    (m_ack),
    .err_q    (m_err)
  );

  bwb_wr_steer u_steer (
    .active     (state == SQ_RUN),
    .wr         (!rnw_q),
    .wdata      (wdata_q),
    .n_total    (n_q),
    .idx        (idx_q),
    .rep        (rep),
    .off        (addr_q[1:0]),
    .rem        (rem_q),
    .lanes_data (t_wdata),
    .lanes_en   (t_ds)
  );

  bwb_rd_pack u_pack (
    .hold     (hold_q),
    .rdata    (t_rdata),
    .n_total  (n_q),
    .idx      (idx_q),
    .pb       (pb_now),
    .off      (addr_q[1:0]),
    .cnt      (cnt),
    .packed_q (hold_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnw_q   <= 1'b1;
      n_q     <= 3'd0;
      wdata_q <= '0;
      addr_q  <= '0;
      idx_q   <= 3'd0;
      rem_q   <= 3'd0;
      pb_q    <= 3'd0;
      hold_q  <= '0;
    end else if (accept && req_ok) begin
      rnw_q   <= m_rnw;
      n_q     <= op_bytes(m_size);
      wdata_q <= m_wdata;
      addr_q  <= m_addr;
      idx_q   <= 3'd0;
      rem_q   <= op_bytes(m_size);
      pb_q    <= 3'd0;
      hold_q  <= '0;
    end else if (sub_hit && !sub_bad) begin
      addr_q <= addr_q + {{(AW-3){1'b0}}, cnt};
      idx_q  <= idx_q + cnt;
      rem_q  <= rem_q - cnt;
      pb_q   <= pb_now;
      if (rnw_q) hold_q <= hold_next;
    end
  end

  assign m_busy  = (state != SQ_IDLE);
  assign m_rdata = hold_q;
  assign t_as    = (state == SQ_RUN);
  assign t_rnw   = rnw_q;
  assign t_addr  = addr_q;
endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          req_ok,
  input logic          sub_hit,
  input logic          m_ack,
  input logic          m_err,
  input logic          m_busy,
  input logic          t_as,
  input logic          t_ack,
  input logic          t_berr,
  input logic [AW-1:0] t_addr,
  input logic [3:0]    t_ds
);
  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_ok |=> m_err && !t_as);

  p_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_as && !t_ack && !t_berr |=> t_as && $stable(t_addr) && $stable(t_ds));

  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_hit |=> !t_as);

  p_lanes_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    t_as |-> t_ds != 4'b0000);

  p_ack_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack |-> $past(m_busy));

  p_berr_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    t_as && t_berr |=> m_err && !m_ack && !t_as);

  p_resp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_ack && m_err));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_ok |=> m_busy);
endmodule

bind bus_width_bridge bwb_checker #(.AW(AW)) u_bwb_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept  (accept),
  .req_ok  (req_ok),
  .sub_hit (sub_hit),
  .m_ack   (m_ack),
  .m_err   (m_err),
  .m_busy  (m_busy),
  .t_as    (t_as),
  .t_ack   (t_ack),
  .t_berr  (t_berr),
  .t_addr  (t_addr),
  .t_ds    (t_ds)
);

// File: tb/bus_width_bridge_test.sv
module bus_width_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          m_start, m_rnw;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_size;
  logic [31:0]   m_wdata;
  logic          m_ack, m_err, m_busy;
  logic [31:0]   m_rdata;
  logic          t_as, t_rnw;
  logic [AW-1:0] t_addr;
  logic [3:0]    t_ds;
  logic [31:0]   t_wdata;
  logic          t_ack, t_berr;
  logic [1:0]    t_psize;
  logic [31:0]   t_rdata;

  int vectors = 0;
  int fails = 0;
  int wst = 0;
  int strobes = 0;
  bit finished = 0;

  logic [7:0] tmem [0:127];
  logic [7:0] smem [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_width_bridge #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .m_start(m_start), .m_rnw(m_rnw), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .m_busy(m_busy),
    .t_as(t_as), .t_rnw(t_rnw), .t_addr(t_addr), .t_ds(t_ds), .t_wdata(t_wdata),
    .t_ack(t_ack), .t_berr(t_berr), .t_psize(t_psize), .t_rdata(t_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Target model. Regions by address bits 6:4: 0/6/7 = 32-bit, 1 = 8-bit,
  // 2 = 16-bit, 3 = always bus error, 4 = reserved width code,
  // 5 = 8-bit with bus error at offset 2 of each word.
  initial begin
    bit acked;
    int cnt;
    bit prev_as;
    for (int i = 0; i < 128; i++) tmem[i] = 8'(i * 37 + 11);
    t_ack = 0; t_berr = 0; t_psize = 0; t_rdata = 0;
    acked = 0; cnt = 0; prev_as = 0;
    forever begin
      @(negedge clk);
      if (t_as && !prev_as) strobes++;
      prev_as = t_as;
      if (!t_as) begin
        t_ack = 0; t_berr = 0; acked = 0; cnt = 0;
      end else if (acked) begin
        t_ack = 0; t_berr = 0;
      end else if (cnt < wst) begin
        cnt++;
      end else begin
        int a, r, w, base, lo;
        logic [31:0] rd;
        a = int'(t_addr[6:0]);
        r = (a >> 4) & 7;
        acked = 1;
        if (r == 3 || (r == 5 && (a & 3) == 2)) begin
          t_berr = 1;
        end else if (r == 4) begin
          t_ack = 1; t_psize = 2'b11;
        end else begin
          w = (r == 1 || r == 5) ? 1 : (r == 2) ? 2 : 4;
          t_psize = (w == 1) ? 2'b01 : (w == 2) ? 2'b10 : 2'b00;
          base = a & ~(w - 1);
          lo = base & 3;
          rd = 0;
          for (int k = 0; k < w; k++) begin
            if (!t_rnw && t_ds[lo + k]) tmem[base + k] = t_wdata[31 - 8*k -: 8];
            rd = rd | (32'(tmem[base + k]) << (24 - 8*k));
          end
          t_rdata = rd;
          t_ack = 1;
        end
      end
    end
  end

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 4 : (sz == 2'b10) ? 2 : (sz == 2'b01) ? 1 : 0;
  endfunction

  task automatic run_one(input bit rnw, input int a, input logic [1:0] sz,
                         input logic [31:0] wd);
    int n, r, w, exp_kind, exp_cyc, good, kind, lat, bad;
    bit okal, busy1;
    logic [31:0] exp_rd, rd;
    string rtag;
    n = nbytes(sz);
    r = (a >> 4) & 7;
    w = (r == 1 || r == 5) ? 1 : (r == 2) ? 2 : 4;
    okal = (n != 0) && ((a % n) == 0);
    good = 0;
    if (!okal) begin
      exp_kind = 2; exp_cyc = 0; rtag = "R2";
    end else if (r == 3 || r == 4) begin
      exp_kind = 2; exp_cyc = 1; rtag = "R8";
    end else if (r == 5) begin
      exp_kind = 1; exp_cyc = n; good = n; rtag = "R8";
      for (int p = 0; p < n; p++)
        if (exp_kind == 1 && ((a + p) & 3) == 2) begin
          exp_kind = 2; exp_cyc = p + 1; good = p;
        end
    end else begin
      exp_kind = 1; exp_cyc = (n > w) ? n / w : 1; good = n; rtag = "R7";
    end
    exp_rd = 0;
    for (int i = 0; i < n; i++) exp_rd = (exp_rd << 8) | 32'(smem[a + i]);
    if (!rnw) for (int i = 0; i < good; i++) smem[a + i] = wd[(n - 1 - i) * 8 +: 8];

    // drive the request
    @(negedge clk);
    strobes = 0;
    m_start = 1; m_rnw = rnw; m_addr = AW'(a); m_size = sz; m_wdata = wd;
    @(negedge clk);
    m_start = 0;
    m_wdata = 32'hDEAD_BEEF;
    lat = 1; kind = 0; busy1 = m_busy;
    while (lat < 400) begin
      if (m_ack || m_err) begin
        kind = m_ack ? 1 : 2;
        break;
      end
      @(negedge clk);
      lat++;
    end
    rd = m_rdata;
    chk(kind == exp_kind, rtag, "response kind", 32'(kind), 32'(exp_kind));
    chk(!(m_ack && m_err) && !m_busy, "R9", "response exclusive, busy low", {m_ack, m_err, m_busy}, 32'd0);
    if (exp_kind == 1 || exp_cyc > 0)
      chk(busy1 == 1'b1, "R9", "busy after accept", 32'(busy1), 32'd1);
    chk(strobes == exp_cyc, "R4", "strobe count", 32'(strobes), 32'(exp_cyc));
    if (!okal) chk(lat == 1, "R2", "refusal latency", 32'(lat), 32'd1);
    if (exp_kind == 1)
      chk(lat == exp_cyc * (2 + wst), "R7", "ack latency", 32'(lat), 32'(exp_cyc * (2 + wst)));
    if (exp_kind == 1 && rnw) chk(rd === exp_rd, "R6", "read data", rd, exp_rd);
    if (!rnw) begin
      bad = 0;
      for (int i = 0; i < 128; i++) if (tmem[i] !== smem[i]) bad++;
      chk(bad == 0, "R5", "target memory bytes differing", 32'(bad), 32'd0);
    end
    // response must be a single pulse
    @(negedge clk);
    chk(!m_ack && !m_err, "R7", "single response pulse", {m_ack, m_err}, 32'd0);
  endtask

  initial begin
    m_start = 0; m_rnw = 1; m_addr = 0; m_size = 0; m_wdata = 0;
    rst_n = 0;
    for (int i = 0; i < 128; i++) smem[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    chk(!t_as && !m_ack && !m_err && !m_busy && t_ds == 4'b0, "R1", "reset outputs",
        {t_as, m_ack, m_err, m_busy, t_ds}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!t_as && !m_busy, "R1", "idle after reset", {t_as, m_busy}, 32'd0);

    // sweep port widths, sizes, offsets, both directions, varying wait states
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 3; s++) begin
        logic [1:0] sz;
        int n;
        sz = (s == 0) ? 2'b00 : (s == 1) ? 2'b10 : 2'b01;
        n = nbytes(sz);
        for (int off = 0; off < 16; off += n) begin
          logic [31:0] wd;
          wd = 32'hA5C3_9617 ^ (32'(r * 16 + off) * 32'h0103_0507) ^ 32'(s << 20);
          wst = (r + off + s) % 3;
          run_one(1'b0, r * 16 + off, sz, wd);
          wst = (off + 1) % 3;
          run_one(1'b1, r * 16 + off, sz, 32'h0);
        end
      end

    // refused requests (R2)
    wst = 0;
    run_one(1'b1, 1, 2'b00, 32'h0);
    run_one(1'b0, 2, 2'b00, 32'h1122_3344);
    run_one(1'b1, 35, 2'b10, 32'h0);
    run_one(1'b0, 17, 2'b10, 32'h5566);
    run_one(1'b1, 4, 2'b11, 32'h0);

    // error terminations (R8)
    wst = 1;
    run_one(1'b1, 48, 2'b00, 32'h0);
    run_one(1'b0, 50, 2'b10, 32'h7788);
    run_one(1'b1, 64, 2'b01, 32'h0);
    run_one(1'b0, 68, 2'b00, 32'h99AA_BBCC);
    wst = 0;
    run_one(1'b1, 80, 2'b00, 32'h0);
    run_one(1'b0, 84, 2'b00, 32'h0BAD_F00D);
    run_one(1'b0, 82, 2'b10, 32'h1234);
    run_one(1'b1, 83, 2'b01, 32'h0);
    run_one(1'b1, 88, 2'b10, 32'h0);
    run_one(1'b0, 96, 2'b00, 32'hCAFE_0042);
    run_one(1'b1, 96, 2'b00, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule